// File: doc/BRIEF.md
# Five-State Snooping Line Coherence Controller

This block keeps the coherence state of every line in a small direct-mapped cache that sits on a shared snooping bus. The cache is write-back and allocates on writes. Each line has a tag and one of five states. Two states are clean and two are dirty-and-owned, each in an exclusive or a shared form. The fifth state is empty. A dirty line may be shared by several caches. The cache that holds it owned, not memory, is the source of the data, and it supplies that data to other readers by cache-to-cache intervention.

The core side presents one request at a time: read, write or evict, for a line address. It holds the request until `cpu_done_o` pulses. On the bus side the block issues commands, and it watches the commands that other agents put on the bus. It raises `cci_o` when it must override memory's reply. Each time it writes a line state it reports the set index and the new state on the update port. The bus's shared response is read only in the cycle after a coherent read is issued. Only the fill state depends on it, never the command.

Top module: `coh_ctrl`

## Requirements
- R1: After reset every line is empty (state code 0). The first access to any line therefore misses, and no snoop causes an intervention or an update.
- R2: A read miss issues bus command 1 (coherent read) for the requested line in the request cycle. In the next cycle the line is filled and `cpu_done_o` pulses. The fill state is 3 (clean shared) if `bus_shared_i` is high in that cycle, and 1 (clean exclusive) if it is low.
- R3: A write miss issues command 2 (read with invalidate) and completes in the same cycle, leaving the line in state 2 (owned exclusive).
- R4: On a write hit, state 1 becomes 2 with no bus command, and state 2 stays unchanged with no command. States 3 and 4 (owned shared) issue command 3 (invalidate) and become 2.
- R5: A read hit completes in the request cycle with no bus command and no state update.
- R6: An evict request that hits an owned line (state 2 or 4) issues command 4 (block write-back) and empties the line. A hit on a clean line empties it without a command. An evict request that misses completes with no command and no update.
- R7: A read or write miss whose set holds a different tag in an owned state first writes that victim back with command 4, using the victim's line address. The victim line is emptied, `cpu_done_o` stays low, and the held request proceeds in the following cycle.
- R8: A snooped coherent read (snoop code 1) that hits moves state 1 to 3 and state 2 to 4. It raises `cci_o` only when the line is owned. State 4 is reachable only from state 2.
- R9: A snooped read with invalidate (code 2) that hits empties the line, and raises `cci_o` if the line was owned.
- R10: A snooped invalidate (code 3) that hits empties a line in state 3 or 4. A snooped block write-back (code 4) changes nothing.
- R11: A snooped DMA write with invalidate (code 5) that hits empties the line in any state, with no intervention and no write-back.
- R12: A snoop that arrives in the same cycle as a core request is handled first. The core request gets no done and no bus command in that cycle, and completes in a later cycle.
- R13: A snoop whose tag does not match, or whose line is empty, causes no intervention and no update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Core request valid, held until done |
| cpu_op_i | input | 2 | 0 read, 1 write, 2 evict |
| cpu_line_i | input | TAG_W+IDX_W | Core line address, tag above index |
| cpu_done_o | output | 1 | Core request completes this cycle |
| snp_vld_i | input | 1 | Snooped bus command valid |
| snp_cmd_i | input | 3 | Snooped command code |
| snp_line_i | input | TAG_W+IDX_W | Snooped line address |
| bus_vld_o | output | 1 | Block issues a bus command |
| bus_cmd_o | output | 3 | Issued command code |
| bus_line_o | output | TAG_W+IDX_W | Line address of the issued command |
| bus_shared_i | input | 1 | Another cache holds a copy (valid in fill cycle) |
| cci_o | output | 1 | Cache-to-cache intervention, overrides memory |
| upd_vld_o | output | 1 | A line state is written this cycle |
| upd_idx_o | output | IDX_W | Set index being written |
| upd_state_o | output | 3 | New line state |

## Verification
The hardest case to reach is a miss that lands on an owned line of a different tag. The bench must first take a line to an owned state, then issue a read to another tag in the same set. It then has to see the victim write-back, the stalled done and the refill over three cycles, with the shared response toggled in the fill cycle. A second hard case is a snoop and a core write in the same cycle on a clean exclusive line. Here the snoop demotes the line first, so the retried write must issue an invalidate rather than upgrade silently. Directed sequences build both situations. A random phase follows, drawing addresses from three tags over four sets, so that conflicts, ownership hand-offs and snoop collisions recur. Every cycle is compared against a behavioural model.

// File: rtl/coh_pkg.sv
`timescale 1ns/1ps
package coh_pkg;
  typedef enum logic [2:0] {
    ST_I  = 3'd0,
    ST_CE = 3'd1,
    ST_OE = 3'd2,
    ST_CS = 3'd3,
    ST_OS = 3'd4
  } line_st_e;

  typedef enum logic [2:0] {
    BC_NONE = 3'd0,
    BC_CR   = 3'd1,
    BC_CRI  = 3'd2,
    BC_CI   = 3'd3,
    BC_WB   = 3'd4,
    BC_CWI  = 3'd5
  } bus_cmd_e;

  localparam logic [1:0] OP_RD  = 2'd0;
  localparam logic [1:0] OP_WR  = 2'd1;
  localparam logic [1:0] OP_RPL = 2'd2;

  function automatic logic is_owned(line_st_e s);
    return (s == ST_OE) || (s == ST_OS);
  endfunction
endpackage

// File: rtl/coh_line_store.sv
`timescale 1ns/1ps
module coh_line_store
  import coh_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] a_idx_i,
  output line_st_e         a_st_o,
  output logic [TAG_W-1:0] a_tag_o,
  input  logic [IDX_W-1:0] b_idx_i,
  output line_st_e         b_st_o,
  output logic [TAG_W-1:0] b_tag_o,
  input  logic             we_i,
  input  logic [IDX_W-1:0] w_idx_i,
  input  line_st_e         w_st_i,
  input  logic [TAG_W-1:0] w_tag_i
);
  localparam int SETS = 1 << IDX_W;

  line_st_e         st_q  [SETS];
  logic [TAG_W-1:0] tag_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SETS; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
      end
    end else if (we_i) begin
      st_q[w_idx_i]  <= w_st_i;
      tag_q[w_idx_i] <= w_tag_i;
    end
  end

  assign a_st_o  = st_q[a_idx_i];
  assign a_tag_o = tag_q[a_idx_i];
  assign b_st_o  = st_q[b_idx_i];
  assign b_tag_o = tag_q[b_idx_i];

  // owned-shared may only be entered from owned-exclusive
  assert_os_entry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && w_st_i == ST_OS) |-> (st_q[w_idx_i] == ST_OE || st_q[w_idx_i] == ST_OS));
endmodule

// File: rtl/coh_snoop_resp.sv
`timescale 1ns/1ps
module coh_snoop_resp
  import coh_pkg::*;
(
  input  logic     hit_i,
  input  bus_cmd_e cmd_i,
  input  line_st_e st_i,
  output logic     cci_o,
  output logic     upd_o,
  output line_st_e nst_o
);
  always_comb begin
    cci_o = 1'b0;
    upd_o = 1'b0;
    nst_o = st_i;
    if (hit_i) begin
      unique case (cmd_i)
        BC_CR: begin
          cci_o = is_owned(st_i);
          if (st_i == ST_CE) begin upd_o = 1'b1; nst_o = ST_CS; end
          if (st_i == ST_OE) begin upd_o = 1'b1; nst_o = ST_OS; end
        end
        BC_CRI: begin
          cci_o = is_owned(st_i);
          upd_o = 1'b1;
          nst_o = ST_I;
        end
        BC_CI: begin
          if (st_i == ST_CS || st_i == ST_OS) begin upd_o = 1'b1; nst_o = ST_I; end
        end
        BC_CWI: begin
          upd_o = 1'b1;
          nst_o = ST_I;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/coh_cpu_resp.sv
`timescale 1ns/1ps
module coh_cpu_resp
  import coh_pkg::*;
(
  input  logic       hit_i,
  input  logic [1:0] op_i,
  input  line_st_e   st_i,
  output bus_cmd_e   cmd_o,
  output logic       victim_o,
  output logic       fill_o,
  output logic       done_o,
  output logic       upd_o,
  output line_st_e   nst_o
);
  always_comb begin
    cmd_o    = BC_NONE;
    victim_o = 1'b0;
    fill_o   = 1'b0;
    done_o   = 1'b0;
    upd_o    = 1'b0;
    nst_o    = st_i;
    if (!hit_i) begin
      if (op_i == OP_RPL) begin
        done_o = 1'b1;
      end else if (is_owned(st_i)) begin
        // dirty victim leaves first; request retries next cycle
        cmd_o    = BC_WB;
        victim_o = 1'b1;
        upd_o    = 1'b1;
        nst_o    = ST_I;
      end else if (op_i == OP_WR) begin
        cmd_o  = BC_CRI;
        done_o = 1'b1;
        upd_o  = 1'b1;
        nst_o  = ST_OE;
      end else begin
        cmd_o  = BC_CR;
        fill_o = 1'b1;
      end
    end else begin
      done_o = 1'b1;
      if (op_i == OP_WR) begin
        if (st_i != ST_OE) begin
          upd_o = 1'b1;
          nst_o = ST_OE;
          if (st_i == ST_CS || st_i == ST_OS) cmd_o = BC_CI;
        end
      end else if (op_i == OP_RPL) begin
        upd_o = 1'b1;
        nst_o = ST_I;
        if (is_owned(st_i)) cmd_o = BC_WB;
      end
    end
  end
endmodule

// File: rtl/coh_ctrl.sv
`timescale 1ns/1ps
module coh_ctrl
  import coh_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cpu_req_i,
  input  logic [1:0]             cpu_op_i,
  input  logic [TAG_W+IDX_W-1:0] cpu_line_i,
  output logic                   cpu_done_o,
  input  logic                   snp_vld_i,
  input  logic [2:0]             snp_cmd_i,
  input  logic [TAG_W+IDX_W-1:0] snp_line_i,
  output logic                   bus_vld_o,
  output logic [2:0]             bus_cmd_o,
  output logic [TAG_W+IDX_W-1:0] bus_line_o,
  input  logic                   bus_shared_i,
  output logic                   cci_o,
  output logic                   upd_vld_o,
  output logic [IDX_W-1:0]       upd_idx_o,
  output logic [2:0]             upd_state_o
);
  logic [IDX_W-1:0] c_idx, s_idx, w_idx, wt_idx_q;
  logic [TAG_W-1:0] c_tag, s_tag, a_tag, b_tag, w_tag, wt_tag_q;
  line_st_e         a_st, b_st, w_st, s_nst, c_nst;
  bus_cmd_e         c_cmd, bus_cmd;
  logic             c_hit, s_hit, s_cci, s_upd, c_vic, c_fill, c_done, c_upd;
  logic             we, wait_q, wait_d;

  assign c_idx = cpu_line_i[IDX_W-1:0];
  assign c_tag = cpu_line_i[TAG_W+IDX_W-1:IDX_W];
  assign s_idx = snp_line_i[IDX_W-1:0];
  assign s_tag = snp_line_i[TAG_W+IDX_W-1:IDX_W];

  coh_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .a_idx_i (c_idx),
    .a_st_o  (a_st),
    .a_tag_o (a_tag),
    .b_idx_i (s_idx),
    .b_st_o  (b_st),
    .b_tag_o (b_tag),
    .we_i    (we),
    .w_idx_i (w_idx),
    .w_st_i  (w_st),
    .w_tag_i (w_tag)
  );

  assign c_hit = (a_st != ST_I) && (a_tag == c_tag);
  assign s_hit = (b_st != ST_I) && (b_tag == s_tag);

  coh_snoop_resp u_snp (
    .hit_i (s_hit),
    .cmd_i (bus_cmd_e'(snp_cmd_i)),
    .st_i  (b_st),
    .cci_o (s_cci),
    .upd_o (s_upd),
    .nst_o (s_nst)
  );

  coh_cpu_resp u_cpu (
    .hit_i    (c_hit),
    .op_i     (cpu_op_i),
    .st_i     (a_st),
    .cmd_o    (c_cmd),
    .victim_o (c_vic),
    .fill_o   (c_fill),
    .done_o   (c_done),
    .upd_o    (c_upd),
    .nst_o    (c_nst)
  );

  always_comb begin
    bus_vld_o  = 1'b0;
    bus_cmd    = BC_NONE;
    bus_line_o = cpu_line_i;
    cci_o      = 1'b0;
    cpu_done_o = 1'b0;
    we         = 1'b0;
    w_idx      = c_idx;
    w_tag      = c_tag;
    w_st       = ST_I;
    wait_d     = 1'b0;
    if (wait_q) begin
      // fill cycle: shared response picks the clean state
      cpu_done_o = 1'b1;
      we         = 1'b1;
      w_idx      = wt_idx_q;
      w_tag      = wt_tag_q;
      w_st       = bus_shared_i ? ST_CS : ST_CE;
    end else if (snp_vld_i) begin
      cci_o = s_cci;
      we    = s_upd;
      w_idx = s_idx;
      w_tag = b_tag;
      w_st  = s_nst;
    end else if (cpu_req_i) begin
      bus_cmd    = c_cmd;
      bus_vld_o  = (c_cmd != BC_NONE);
      if (c_vic) bus_line_o = {a_tag, c_idx};
      cpu_done_o = c_done;
      we         = c_upd;
      w_st       = c_nst;
      wait_d     = c_fill;
    end
  end

  assign bus_cmd_o   = bus_cmd;
  assign upd_vld_o   = we;
  assign upd_idx_o   = w_idx;
  assign upd_state_o = w_st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q   <= 1'b0;
      wt_idx_q <= '0;
      wt_tag_q <= '0;
    end else begin
      wait_q <= wait_d;
      if (wait_d) begin
        wt_idx_q <= c_idx;
        wt_tag_q <= c_tag;
      end
    end
  end

  assert_fill_next_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_vld_o && bus_cmd_o == BC_CR) |=> (cpu_done_o && upd_vld_o && !bus_vld_o));

  assert_snoop_first_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_vld_i && !wait_q) |-> (!cpu_done_o && !bus_vld_o));

  assert_cci_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cci_o |-> (snp_vld_i && (snp_cmd_i == BC_CR || snp_cmd_i == BC_CRI)));

  assert_wb_empties_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_vld_o && bus_cmd_o == BC_WB) |-> (upd_vld_o && upd_state_o == ST_I));

  // fill cycle belongs to this block: no snoop may arrive then
  assert_fill_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_q |-> !snp_vld_i);
endmodule

// File: tb/tb_coh_ctrl.sv
`timescale 1ns/1ps
module tb_coh_ctrl;
  localparam int IW = 3;
  localparam int TW = 8;
  localparam int LW = IW + TW;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          cpu_req = 1'b0, snp_vld = 1'b0, shared = 1'b0;
  logic [1:0]    cpu_op = '0;
  logic [2:0]    snp_cmd = '0;
  logic [LW-1:0] cpu_line = '0, snp_line = '0;
  logic          cpu_done, bus_vld, cci, upd_vld;
  logic [2:0]    bus_cmd, upd_state;
  logic [LW-1:0] bus_line;
  logic [IW-1:0] upd_idx;

  int n_chk = 0, n_bad = 0;

  int            m_st  [8];
  logic [TW-1:0] m_tag [8];
  bit            m_wait = 0;
  int            w_i;
  logic [TW-1:0] w_t;
  logic [1:0]    h_op;
  logic [LW-1:0] h_ln;

  always #2 clk = ~clk;

  coh_ctrl #(.IDX_W(IW), .TAG_W(TW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_op_i(cpu_op), .cpu_line_i(cpu_line), .cpu_done_o(cpu_done),
    .snp_vld_i(snp_vld), .snp_cmd_i(snp_cmd), .snp_line_i(snp_line),
    .bus_vld_o(bus_vld), .bus_cmd_o(bus_cmd), .bus_line_o(bus_line), .bus_shared_i(shared),
    .cci_o(cci), .upd_vld_o(upd_vld), .upd_idx_o(upd_idx), .upd_state_o(upd_state)
  );

  function automatic logic [LW-1:0] ln(int t, int i);
    return {TW'(t), IW'(i)};
  endfunction

  task automatic cyc(string rq, bit req, logic [1:0] op, logic [LW-1:0] cl,
                     bit sv, logic [2:0] sc, logic [LW-1:0] sl, bit sh);
    bit e_bv = 0, e_cci = 0, e_done = 0, e_uv = 0, nwait = 0, hit, own;
    int e_bc = 0, e_us = 0, e_ui, st, ci, si;
    logic [LW-1:0] e_bl;
    logic [TW-1:0] e_ut;
    if (m_wait) begin req = 1; op = h_op; cl = h_ln; sv = 0; end
    cpu_req = req; cpu_op = op; cpu_line = cl;
    snp_vld = sv; snp_cmd = sc; snp_line = sl; shared = sh;
    #1;
    ci = int'(cl[IW-1:0]); e_ui = ci; e_ut = cl[LW-1:IW]; e_bl = cl;
    if (m_wait) begin
      e_done = 1; e_uv = 1; e_ui = w_i; e_ut = w_t; e_us = sh ? 3 : 1;
    end else if (sv) begin
      si = int'(sl[IW-1:0]); st = m_st[si];
      hit = (st != 0) && (m_tag[si] == sl[LW-1:IW]);
      own = (st == 2) || (st == 4);
      e_ui = si; e_ut = m_tag[si];
      if (hit) begin
        if (sc == 1) begin
          e_cci = own;
          if (st == 1) begin e_uv = 1; e_us = 3; end
          if (st == 2) begin e_uv = 1; e_us = 4; end
        end else if (sc == 2) begin
          e_cci = own; e_uv = 1; e_us = 0;
        end else if (sc == 3) begin
          if (st == 3 || st == 4) begin e_uv = 1; e_us = 0; end
        end else if (sc == 5) begin
          e_uv = 1; e_us = 0;
        end
      end
    end else if (req) begin
      st = m_st[ci];
      hit = (st != 0) && (m_tag[ci] == cl[LW-1:IW]);
      own = (st == 2) || (st == 4);
      if (!hit) begin
        if (op == 2) e_done = 1;
        else if (own) begin
          e_bv = 1; e_bc = 4; e_bl = {m_tag[ci], cl[IW-1:0]}; e_uv = 1; e_us = 0;
        end else if (op == 0) begin
          e_bv = 1; e_bc = 1; nwait = 1;
        end else begin
          e_bv = 1; e_bc = 2; e_done = 1; e_uv = 1; e_us = 2;
        end
      end else begin
        e_done = 1;
        if (op == 1) begin
          if (st != 2) begin e_uv = 1; e_us = 2; end
          if (st == 3 || st == 4) begin e_bv = 1; e_bc = 3; end
        end else if (op == 2) begin
          e_uv = 1; e_us = 0;
          if (own) begin e_bv = 1; e_bc = 4; end
        end
      end
    end
    n_chk++;
    if (bus_vld !== e_bv || (e_bv && (int'(bus_cmd) != e_bc || bus_line !== e_bl)) ||
        cci !== e_cci || cpu_done !== e_done || upd_vld !== e_uv ||
        (e_uv && (int'(upd_state) != e_us || int'(upd_idx) != e_ui))) begin
      n_bad++;
      $display("FAIL %s: got bv=%0b bc=%0d bl=%h cci=%0b done=%0b uv=%0b ui=%0d us=%0d exp bv=%0b bc=%0d bl=%h cci=%0b done=%0b uv=%0b ui=%0d us=%0d",
               rq, bus_vld, bus_cmd, bus_line, cci, cpu_done, upd_vld, upd_idx, upd_state,
               e_bv, e_bc, e_bl, e_cci, e_done, e_uv, e_ui, e_us);
    end
    @(posedge clk);
    if (e_uv) begin m_st[e_ui] = e_us; m_tag[e_ui] = e_ut; end
    m_wait = nwait;
    if (nwait) begin w_i = ci; w_t = cl[LW-1:IW]; h_op = op; h_ln = cl; end
    @(negedge clk);
  endtask

  task automatic cpu(string rq, logic [1:0] op, logic [LW-1:0] cl, bit sh);
    cyc(rq, 1, op, cl, 0, 0, '0, sh);
  endtask

  task automatic snp(string rq, logic [2:0] sc, logic [LW-1:0] sl);
    cyc(rq, 0, 0, '0, 1, sc, sl, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_st[i] = 0; m_tag[i] = '0; end
    repeat (3) @(negedge clk);
    // R1: outputs idle in reset
    n_chk++;
    if (cpu_done !== 0 || bus_vld !== 0 || cci !== 0 || upd_vld !== 0) begin
      n_bad++;
      $display("FAIL R1: reset outputs done=%0b bv=%0b cci=%0b uv=%0b exp 0", cpu_done, bus_vld, cci, upd_vld);
    end
    rst_n = 1'b1;
    @(negedge clk);
    snp("R1", 1, ln(1, 0));
    cpu("R1", 0, ln(1, 0), 0);
    cpu("R2", 0, ln(1, 0), 0);          // fill cycle, exclusive
    cpu("R5", 0, ln(1, 0), 1);
    cpu("R4", 1, ln(1, 0), 0);          // CE -> OE silent
    cpu("R4", 1, ln(1, 0), 0);          // OE stays
    snp("R8", 1, ln(1, 0));             // OE -> OS with intervention
    snp("R8", 1, ln(1, 0));             // OS stays, intervenes
    cpu("R4", 1, ln(1, 0), 0);          // OS -> CI -> OE
    snp("R9", 2, ln(1, 0));
    cpu("R3", 1, ln(1, 0), 1);
    cpu("R7", 0, ln(2, 0), 0);          // victim write-back
    cpu("R7", 0, ln(2, 0), 0);          // now CR
    cpu("R2", 0, ln(2, 0), 1);          // fill shared
    snp("R8", 1, ln(2, 0));             // CS unchanged
    cpu("R4", 1, ln(2, 0), 0);          // CS -> CI -> OE
    snp("R10", 4, ln(2, 0));
    snp("R8", 1, ln(2, 0));
    snp("R10", 3, ln(2, 0));            // OS -> I
    cpu("R3", 1, ln(3, 1), 0);
    cpu("R6", 2, ln(3, 1), 0);
    cpu("R6", 2, ln(3, 1), 0);
    cpu("R6", 0, ln(3, 1), 0);
    cpu("R6", 0, ln(3, 1), 0);
    cpu("R6", 2, ln(3, 1), 0);
    cpu("R11", 1, ln(3, 1), 0);
    snp("R11", 5, ln(3, 1));
    cpu("R12", 0, ln(3, 1), 0);
    cpu("R12", 0, ln(3, 1), 0);
    cyc("R12", 1, 1, ln(3, 1), 1, 1, ln(3, 1), 0);
    cpu("R12", 1, ln(3, 1), 0);
    snp("R13", 1, ln(5, 1));
    snp("R13", 2, ln(5, 1));
    snp("R13", 5, ln(4, 2));
    for (int k = 0; k < 4000; k++) begin
      cyc("RND", ($urandom % 4) != 0, 2'($urandom % 3), ln(1 + $urandom % 3, $urandom % 4),
          ($urandom % 3) == 0, 3'($urandom % 6), ln(1 + $urandom % 3, $urandom % 4),
          1'($urandom % 2));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule